// File: doc/BRIEF.md
# DMA Channel Control and Status Register File

This block is the register front end for a set of descriptor-driven DMA channels. Each channel owns a window of sixteen 32-bit words on a word-addressed memory-mapped bus. The upper address bits pick the channel and the low four bits pick the word. The block keeps the channel status word and the command pointer. It also stores the three condition-select words that the sequencer uses for its interrupt, branch and wait tests. It hands the sequencer one-cycle request pulses.

Software drives a channel through the control word. Its upper half is a per-bit write mask and its lower half holds the new values. The run, pause, flush, wake and device-status bits are merged into the status word. ACTIVE and DEAD are then derived from them by a fixed rule order. The command pointer is 16-byte aligned and cannot be changed while the channel is running or active. Kill and stop events come from the sequencer as strobes and update the status word directly.

Top module: `dmac_chan_regs`

## Requirements
- R1: After synchronous reset every word of every channel reads 0, and all request pulses and command pointers are 0.
- R2: A write to word 0 treats bits 31:16 as a mask and bits 15:0 as values. Only status bits 15 (run), 14 (pause), 13 (flush), 12 (wake) and 7:0 (device status) may take a 1 from the value. Every masked bit takes the filtered value, and every unmasked bit keeps its old value.
- R3: After the merge, wake set forces ACTIVE (bit 10) to 1, and run set forces ACTIVE to 1 and clears DEAD (bit 11).
- R4: Pause set clears ACTIVE, and this overrides run and wake.
- R5: If a control write changes run from 1 to 0, both ACTIVE and DEAD are cleared.
- R6: A write to the command pointer (word 3) is ignored while run or ACTIVE is set. The stored pointer and the value read back stay the same, and no load pulse is issued.
- R7: An accepted pointer write stores the value with bits 3:0 forced to 0. It shows the new value on `cmd_ptr_o` and gives a one-cycle `ptr_load_o` pulse in the cycle after the write.
- R8: Words 0, 2, 7, 8, 9, 11 and 12 always read 0. Words 4, 5, 6, 10, 13, 14 and 15 read back the last value written, and word 1 reads the status.
- R9: In the cycle after a control write, `start_o` pulses if the resulting status has ACTIVE set, and `flush_o` pulses if it has flush set.
- R10: A kill strobe sets DEAD, clears ACTIVE and pulses `irq_o` in the next cycle.
- R11: A stop strobe clears ACTIVE, DEAD and flush and leaves the other status bits as they were.
- R12: `req_ready` is always 1. A read returns its data with `rsp_valid` exactly one cycle after it is accepted, and `rsp_valid` is 0 at all other times.
- R13: Address bits above bit 3 select the channel. A write to one channel leaves the words of every other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request valid |
| req_ready | output | 1 | Bus request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address: channel in upper bits, word index in bits 3:0 |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| kill_i | input | NUM_CH | Per-channel kill strobe from the sequencer |
| stop_i | input | NUM_CH | Per-channel stop strobe from the sequencer |
| start_o | output | NUM_CH | Start request pulse to the sequencer |
| flush_o | output | NUM_CH | Flush request pulse to the attached device |
| ptr_load_o | output | NUM_CH | Command-pointer load pulse to the sequencer |
| irq_o | output | NUM_CH | Interrupt pulse raised by a kill |
| cmd_ptr_o | output | 32*NUM_CH | Aligned command pointer of each channel |

## Verification
Every result of this block sits one register stage after its cause:
- Status and pointer updates appear one cycle after the bus write or strobe that causes them.
- The start, flush, load and interrupt pulses also appear in that cycle.
- Read data appears with `rsp_valid` in the cycle after the read is accepted.

The bench drives inputs at falling edges and holds each request for exactly one rising edge. It samples pulses and read data at the next falling edge, so every check lands in the single cycle where the result is due. It also checks that `rsp_valid` drops in the following cycle.

// File: rtl/dmac_regs_pkg.sv
package dmac_regs_pkg;

    localparam int unsigned WORD_W      = 32;
    localparam int unsigned IDX_W       = 4;
    localparam int unsigned REGS_PER_CH = 1 << IDX_W;

    // status bit positions
    localparam int unsigned B_RUN    = 15;
    localparam int unsigned B_PAUSE  = 14;
    localparam int unsigned B_FLUSH  = 13;
    localparam int unsigned B_WAKE   = 12;
    localparam int unsigned B_DEAD   = 11;
    localparam int unsigned B_ACTIVE = 10;

    // value bits a control write may set
    localparam logic [15:0] CTL_SETTABLE = 16'hF0FF;

    // word indices
    localparam logic [IDX_W-1:0] IDX_CTL     = 4'd0;
    localparam logic [IDX_W-1:0] IDX_STAT    = 4'd1;
    localparam logic [IDX_W-1:0] IDX_PTR_HI  = 4'd2;
    localparam logic [IDX_W-1:0] IDX_PTR_LO  = 4'd3;
    localparam logic [IDX_W-1:0] IDX_XMODE   = 4'd7;
    localparam logic [IDX_W-1:0] IDX_D2_HI   = 4'd8;
    localparam logic [IDX_W-1:0] IDX_D2_LO   = 4'd9;
    localparam logic [IDX_W-1:0] IDX_ADR_HI  = 4'd11;
    localparam logic [IDX_W-1:0] IDX_BRA_HI  = 4'd12;

    typedef struct packed {
        logic [REGS_PER_CH-1:0][WORD_W-1:0] words;
        logic                               start;
        logic                               flush;
        logic                               ptr_load;
        logic                               irq;
    } chan_state_t;

    typedef struct packed {
        logic              valid;
        logic [WORD_W-1:0] data;
    } rsp_state_t;

    function automatic logic reads_as_zero(input logic [IDX_W-1:0] idx);
        logic z;
        case (idx)
            IDX_CTL, IDX_PTR_HI, IDX_XMODE, IDX_D2_HI,
            IDX_D2_LO, IDX_ADR_HI, IDX_BRA_HI: z = 1'b1;
            default:                           z = 1'b0;
        endcase
        return z;
    endfunction

endpackage

// File: rtl/dmac_ctl_merge.sv
module dmac_ctl_merge
    import dmac_regs_pkg::*;
(
    input  logic [WORD_W-1:0] old_status,
    input  logic [WORD_W-1:0] ctl_word,
    output logic [WORD_W-1:0] new_status
);

    logic [15:0]       mask;
    logic [15:0]       val;
    logic [WORD_W-1:0] s;

    always_comb begin
        mask     = ctl_word[31:16];
        val      = ctl_word[15:0] & CTL_SETTABLE;
        s        = old_status;
        s[15:0]  = (val & mask) | (old_status[15:0] & ~mask);
        if (s[B_WAKE]) begin
            s[B_ACTIVE] = 1'b1;
        end
        if (s[B_RUN]) begin
            s[B_ACTIVE] = 1'b1;
            s[B_DEAD]   = 1'b0;
        end
        if (s[B_PAUSE]) begin
            s[B_ACTIVE] = 1'b0;
        end
        if (old_status[B_RUN] && !s[B_RUN]) begin
            s[B_ACTIVE] = 1'b0;
            s[B_DEAD]   = 1'b0;
        end
        new_status = s;
    end

endmodule

// File: rtl/dmac_chan.sv
module dmac_chan
    import dmac_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              kill,
    input  logic              stop,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_word,
    output logic              start_o,
    output logic              flush_o,
    output logic              ptr_load_o,
    output logic              irq_o,
    output logic [WORD_W-1:0] cmd_ptr_o
);

    chan_state_t       st_q, st_d;
    logic [WORD_W-1:0] merged;
    logic              ctl_hit;
    logic              ptr_hit;
    logic              ptr_locked;

    dmac_ctl_merge u_merge (
        .old_status (st_q.words[IDX_STAT]),
        .ctl_word   (wr_data),
        .new_status (merged)
    );

    assign ctl_hit    = wr_en && (wr_idx == IDX_CTL);
    assign ptr_hit    = wr_en && (wr_idx == IDX_PTR_LO);
    assign ptr_locked = st_q.words[IDX_STAT][B_RUN] || st_q.words[IDX_STAT][B_ACTIVE];

    always_comb begin
        st_d          = st_q;
        st_d.start    = 1'b0;
        st_d.flush    = 1'b0;
        st_d.ptr_load = 1'b0;
        st_d.irq      = 1'b0;

        if (ctl_hit) begin
            st_d.words[IDX_CTL]  = wr_data;
            st_d.words[IDX_STAT] = merged;
        end else if (ptr_hit) begin
            if (!ptr_locked) begin
                st_d.words[IDX_PTR_LO] = {wr_data[WORD_W-1:4], 4'b0000};
                st_d.ptr_load          = 1'b1;
            end
        end else if (wr_en) begin
            st_d.words[wr_idx] = wr_data;
        end

        // sequencer events land on top of any bus update
        if (kill) begin
            st_d.words[IDX_STAT][B_DEAD]   = 1'b1;
            st_d.words[IDX_STAT][B_ACTIVE] = 1'b0;
            st_d.irq                       = 1'b1;
        end else if (stop) begin
            st_d.words[IDX_STAT][B_ACTIVE] = 1'b0;
            st_d.words[IDX_STAT][B_DEAD]   = 1'b0;
            st_d.words[IDX_STAT][B_FLUSH]  = 1'b0;
        end

        if (ctl_hit) begin
            st_d.start = st_d.words[IDX_STAT][B_ACTIVE];
            st_d.flush = st_d.words[IDX_STAT][B_FLUSH];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_word    = reads_as_zero(rd_idx) ? '0 : st_q.words[rd_idx];
    assign start_o    = st_q.start;
    assign flush_o    = st_q.flush;
    assign ptr_load_o = st_q.ptr_load;
    assign irq_o      = st_q.irq;
    assign cmd_ptr_o  = st_q.words[IDX_PTR_LO];

endmodule

// File: rtl/dmac_chan_regs.sv
module dmac_chan_regs
    import dmac_regs_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    localparam int unsigned CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int unsigned ADDR_W = CH_W + IDX_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic                     req_write,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [WORD_W-1:0]        req_wdata,
    output logic                     rsp_valid,
    output logic [WORD_W-1:0]        rsp_rdata,
    input  logic [NUM_CH-1:0]        kill_i,
    input  logic [NUM_CH-1:0]        stop_i,
    output logic [NUM_CH-1:0]        start_o,
    output logic [NUM_CH-1:0]        flush_o,
    output logic [NUM_CH-1:0]        ptr_load_o,
    output logic [NUM_CH-1:0]        irq_o,
    output logic [NUM_CH*WORD_W-1:0] cmd_ptr_o
);

    localparam logic [CH_W:0] CH_COUNT = (CH_W+1)'(NUM_CH);

    logic [CH_W-1:0]   ch_sel;
    logic [IDX_W-1:0]  idx;
    logic              ch_ok;
    logic [WORD_W-1:0] rd_words [NUM_CH];
    rsp_state_t        rsp_q, rsp_d;

    assign req_ready = 1'b1;
    assign ch_sel    = req_addr[ADDR_W-1:IDX_W];
    assign idx       = req_addr[IDX_W-1:0];
    assign ch_ok     = ({1'b0, ch_sel} < CH_COUNT);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic wr_en;
        assign wr_en = req_valid && req_write && (ch_sel == CH_W'(g));

        dmac_chan u_chan (
            .clk        (clk),
            .rst        (rst),
            .wr_en      (wr_en),
            .wr_idx     (idx),
            .wr_data    (req_wdata),
            .kill       (kill_i[g]),
            .stop       (stop_i[g]),
            .rd_idx     (idx),
            .rd_word    (rd_words[g]),
            .start_o    (start_o[g]),
            .flush_o    (flush_o[g]),
            .ptr_load_o (ptr_load_o[g]),
            .irq_o      (irq_o[g]),
            .cmd_ptr_o  (cmd_ptr_o[g*WORD_W +: WORD_W])
        );
    end

    always_comb begin
        rsp_d.valid = req_valid && req_ready && !req_write;
        rsp_d.data  = ch_ok ? rd_words[ch_sel] : '0;
        if (!rsp_d.valid) begin
            rsp_d.data = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_rdata = rsp_q.data;

endmodule

// File: rtl/dmac_regs_chk.sv
module dmac_regs_chk
    import dmac_regs_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    localparam int unsigned CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int unsigned ADDR_W = CH_W + IDX_W
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     req_valid,
    input logic                     req_ready,
    input logic                     req_write,
    input logic [ADDR_W-1:0]        req_addr,
    input logic                     rsp_valid,
    input logic [NUM_CH-1:0]        kill_i,
    input logic [NUM_CH-1:0]        start_o,
    input logic [NUM_CH-1:0]        flush_o,
    input logic [NUM_CH-1:0]        ptr_load_o,
    input logic [NUM_CH-1:0]        irq_o,
    input logic [NUM_CH*WORD_W-1:0] cmd_ptr_o
);

    p_rd_latency_r12: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !req_write) |=> rsp_valid);

    p_no_stray_rsp_r12: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_ready && !req_write) |=> !rsp_valid);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(g * REGS_PER_CH);
        localparam logic [ADDR_W-1:0] A_PTR = ADDR_W'(g * REGS_PER_CH + 3);

        p_ptr_align_r7: assert property (@(posedge clk) disable iff (rst)
            cmd_ptr_o[g*WORD_W +: 4] == 4'b0000);

        p_ptr_load_cause_r7: assert property (@(posedge clk) disable iff (rst)
            ptr_load_o[g] |-> $past(req_valid && req_write && req_addr == A_PTR));

        p_ptr_hold_r6: assert property (@(posedge clk) disable iff (rst)
            !$stable(cmd_ptr_o[g*WORD_W +: WORD_W]) |-> ptr_load_o[g]);

        p_req_cause_r9: assert property (@(posedge clk) disable iff (rst)
            (start_o[g] || flush_o[g]) |-> $past(req_valid && req_write && req_addr == A_CTL));

        p_kill_irq_r10: assert property (@(posedge clk) disable iff (rst)
            kill_i[g] |=> irq_o[g]);

        p_irq_cause_r10: assert property (@(posedge clk) disable iff (rst)
            irq_o[g] |-> $past(kill_i[g]));
    end

endmodule

bind dmac_chan_regs dmac_regs_chk #(.NUM_CH(NUM_CH)) u_regs_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .rsp_valid  (rsp_valid),
    .kill_i     (kill_i),
    .start_o    (start_o),
    .flush_o    (flush_o),
    .ptr_load_o (ptr_load_o),
    .irq_o      (irq_o),
    .cmd_ptr_o  (cmd_ptr_o)
);

// File: tb/tb_dmac_chan_regs.sv
module tb_dmac_chan_regs;

    localparam int NCH = 4;
    localparam int AW  = 6;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic            req_write = 1'b0;
    logic [AW-1:0]   req_addr  = '0;
    logic [31:0]     req_wdata = '0;
    logic            rsp_valid;
    logic [31:0]     rsp_rdata;
    logic [NCH-1:0]  kill_i = '0;
    logic [NCH-1:0]  stop_i = '0;
    logic [NCH-1:0]  start_o, flush_o, ptr_load_o, irq_o;
    logic [NCH*32-1:0] cmd_ptr_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    dmac_chan_regs #(.NUM_CH(NCH)) dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .kill_i(kill_i), .stop_i(stop_i),
        .start_o(start_o), .flush_o(flush_o), .ptr_load_o(ptr_load_o),
        .irq_o(irq_o), .cmd_ptr_o(cmd_ptr_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input int ch, input int idx, input logic [31:0] data);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1;
        req_addr  = AW'(ch * 16 + idx); req_wdata = data;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd_chk(input int ch, input int idx, input logic [31:0] exp, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = AW'(ch * 16 + idx);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R12 rsp_valid with data", {31'b0, rsp_valid}, 32'h1);
        chk(tag, rsp_rdata, exp);
    endtask

    task automatic strobe(input bit is_kill, input int ch);
        @(negedge clk);
        if (is_kill) kill_i[ch] = 1'b1; else stop_i[ch] = 1'b1;
        @(negedge clk);
        kill_i = '0; stop_i = '0;
    endtask

    task automatic pulses(input string tag, input logic [3:0] st, input logic [3:0] fl,
                          input logic [3:0] pl, input logic [3:0] ir);
        chk({tag, " start"},    {28'b0, start_o},    {28'b0, st});
        chk({tag, " flush"},    {28'b0, flush_o},    {28'b0, fl});
        chk({tag, " ptr_load"}, {28'b0, ptr_load_o}, {28'b0, pl});
        chk({tag, " irq"},      {28'b0, irq_o},      {28'b0, ir});
    endtask

    task automatic t_reset();
        pulses("R1 reset", 4'h0, 4'h0, 4'h0, 4'h0);
        chk("R1 cmd_ptr ch0", cmd_ptr_o[31:0], 32'h0);
        chk("R1 cmd_ptr ch3", cmd_ptr_o[127:96], 32'h0);
        chk("R12 ready", {31'b0, req_ready}, 32'h1);
        for (int i = 0; i < 16; i++) rd_chk(0, i, 32'h0, "R1 ch0 word after reset");
        rd_chk(3, 1, 32'h0, "R1 ch3 status after reset");
        rd_chk(3, 4, 32'h0, "R1 ch3 select after reset");
    endtask

    task automatic t_merge();
        wr(0, 0, 32'h00FF_00A5);
        pulses("R2 merge", 4'h0, 4'h0, 4'h0, 4'h0);
        rd_chk(0, 1, 32'h0000_00A5, "R2 device status set");
        wr(0, 0, 32'h000F_0003);
        rd_chk(0, 1, 32'h0000_00A3, "R2 partial mask");
        wr(0, 0, 32'h0C00_0C00);
        chk("R2 no start from filtered bits", {28'b0, start_o}, 32'h0);
        rd_chk(0, 1, 32'h0000_00A3, "R2 DEAD/ACTIVE not settable");
        wr(0, 0, 32'h0000_FFFF);
        rd_chk(0, 1, 32'h0000_00A3, "R2 zero mask keeps status");
    endtask

    task automatic t_flush_stop();
        wr(0, 0, 32'h2000_2000);
        pulses("R9 flush", 4'h0, 4'h1, 4'h0, 4'h0);
        rd_chk(0, 1, 32'h0000_20A3, "R9 flush bit in status");
        rd_chk(0, 0, 32'h0, "R8 control reads zero");
        strobe(1'b0, 0);
        rd_chk(0, 1, 32'h0000_00A3, "R11 stop clears flush");
    endtask

    task automatic t_kill_run();
        strobe(1'b1, 1);
        pulses("R10 kill", 4'h0, 4'h0, 4'h0, 4'h2);
        rd_chk(1, 1, 32'h0000_0800, "R10 kill sets DEAD");
        wr(1, 0, 32'h8000_8000);
        pulses("R9 run start", 4'h2, 4'h0, 4'h0, 4'h0);
        rd_chk(1, 1, 32'h0000_8400, "R3 run sets ACTIVE clears DEAD");
    endtask

    task automatic t_wake_stop();
        wr(2, 0, 32'h1000_1000);
        pulses("R3 wake start", 4'h4, 4'h0, 4'h0, 4'h0);
        rd_chk(2, 1, 32'h0000_1400, "R3 wake sets ACTIVE");
        strobe(1'b0, 2);
        rd_chk(2, 1, 32'h0000_1000, "R11 stop clears ACTIVE keeps wake");
    endtask

    task automatic t_pause();
        wr(1, 0, 32'h4000_4000);
        chk("R4 no start while paused", {28'b0, start_o}, 32'h0);
        rd_chk(1, 1, 32'h0000_C000, "R4 pause overrides run");
    endtask

    task automatic t_run_fall();
        strobe(1'b1, 1);
        rd_chk(1, 1, 32'h0000_C800, "R10 kill while paused");
        wr(1, 0, 32'h8000_0000);
        chk("R5 no start", {28'b0, start_o}, 32'h0);
        rd_chk(1, 1, 32'h0000_4000, "R5 run fall clears ACTIVE and DEAD");
    endtask

    task automatic t_ptr();
        wr(3, 3, 32'h1234_567F);
        pulses("R7 ptr load", 4'h0, 4'h0, 4'h8, 4'h0);
        chk("R7 cmd_ptr aligned", cmd_ptr_o[127:96], 32'h1234_5670);
        rd_chk(3, 3, 32'h1234_5670, "R7 pointer readback");
        wr(3, 0, 32'h8000_8000);
        wr(3, 3, 32'hAAAA_AAA0);
        chk("R6 no load while running", {28'b0, ptr_load_o}, 32'h0);
        rd_chk(3, 3, 32'h1234_5670, "R6 pointer locked by run");
        wr(3, 0, 32'h8000_0000);
        rd_chk(3, 1, 32'h0000_0000, "R5 run cleared");
        wr(3, 0, 32'h1000_1000);
        wr(3, 3, 32'h5555_5550);
        chk("R6 cmd_ptr unchanged while active", cmd_ptr_o[127:96], 32'h1234_5670);
        rd_chk(3, 3, 32'h1234_5670, "R6 pointer locked by active");
        strobe(1'b0, 3);
        wr(3, 3, 32'h0000_0108);
        pulses("R7 reload", 4'h0, 4'h0, 4'h8, 4'h0);
        chk("R7 cmd_ptr after unlock", cmd_ptr_o[127:96], 32'h0000_0100);
    endtask

    task automatic t_words();
        int zero_idx[6] = '{2, 7, 8, 9, 11, 12};
        int keep_idx[7] = '{4, 5, 6, 10, 13, 14, 15};
        foreach (zero_idx[k]) begin
            wr(2, zero_idx[k], 32'hDEAD_0000 | 32'(zero_idx[k]));
            rd_chk(2, zero_idx[k], 32'h0, "R8 zero-reading word");
        end
        foreach (keep_idx[k]) begin
            wr(2, keep_idx[k], 32'h5A5A_0000 | 32'(keep_idx[k]));
            rd_chk(2, keep_idx[k], 32'h5A5A_0000 | 32'(keep_idx[k]), "R8 stored word");
        end
        rd_chk(1, 4, 32'h0, "R13 other channel word untouched");
        rd_chk(2, 1, 32'h0000_1000, "R13 status untouched by word writes");
        rd_chk(0, 1, 32'h0000_00A3, "R13 ch0 status untouched");
    endtask

    task automatic t_latency();
        wr(0, 4, 32'h0000_0042);
        chk("R12 no response to write", {31'b0, rsp_valid}, 32'h0);
        rd_chk(0, 4, 32'h0000_0042, "R12 read data");
        chk("R12 response lasts one cycle", {31'b0, rsp_valid}, 32'h1);
        @(negedge clk);
        chk("R12 response gone", {31'b0, rsp_valid}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_merge();
        t_flush_stop();
        t_kill_run();
        t_wake_stop();
        t_pause();
        t_run_fall();
        t_ptr();
        t_words();
        t_latency();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule